// File: doc/BRIEF.md
# Interrupt Pin to Message Generator

This block watches a bank of 24 interrupt request lines and turns each interrupt event into a single memory-write message on an upstream bus. It first brings every line to an active-high sense. Lines 0 to 15 arrive active-high. Lines 16 to 23 arrive active-low and are inverted. Lines 16 to 19 carry the four PCI-style interrupt wires A to D. Lines 20 to 23 carry wires E to H, which share their pins with general-purpose I/O. When the shared pin of one of these lines is in GPIO mode, that line is held inactive.

Each line runs in edge or level mode, and each line keeps one bit in an interrupt request register. A per-line mask bit suppresses that line's messages. A fixed-priority arbiter serves pending events, lowest index first. Only one write is in flight at a time.

To send a write, the block raises a bus request and waits for a grant, which stands for a flush of the upstream buffers. It then presents the address and data on a valid/ready handshake. Events that arrive while a write is in progress wait in the per-line pending state and are not lost.

Top module: `irqmsg_gen`

## Requirements
- R1: Lines 0 to 15 are asserted when their pin is 1. Lines 16 to 23 are asserted when their pin is 0. In edge mode, driving line 17's pin low produces one assert message for index 17.
- R2: Wire A drives line 16 and wire E drives line 20, up to wire H on line 23. While `gpio_mode_i[k]` is 1, line 20+k is treated as inactive: it sets no request bit and sends no message. When the bit returns to 0 with the pin still asserted, the line is seen as newly asserted.
- R3: In edge mode (`trig_level_i[i]`=0), only an inactive-to-active transition sets request bit i and produces exactly one assert message. The opposite transition produces nothing.
- R4: In level mode (`trig_level_i[i]`=1), `irr_o[i]` equals the normalised level one clock after the pin changes. Every change queues a message whose assert bit is the new level. Changes that arrive while a line's message is still waiting merge into one message that carries the latest level.
- R5: While `mask_i[i]` is 1, line i sends no message. In edge mode its request bit is also not set. In level mode `irr_o[i]` still follows the level.
- R6: Before every write, `bus_req_o` rises and stays high until `bus_gnt_i` is sampled high. `msg_valid_o` rises only after that grant. `bus_req_o` and `msg_valid_o` are never high together.
- R7: Each message is one write. While `msg_valid_o` is high and `msg_ready_i` is low, the valid, address and data outputs hold steady.
- R8: When several events are pending, the lowest index is sent first. A new write starts only after the previous handshake completes.
- R9: The address is 32'hFEE0_0000 OR (`dest_i` << 12). The data word holds bits [7:0] = `vec_base_i` + index (mod 256), bit 14 = 1 for assert and 0 for deassert, and bit 15 = 1 for level mode. All other data bits are 0.
- R10: In edge mode, request bit i clears once its message handshake completes. An edge on another line during a write sets that line's request bit, and its message follows the current one.
- R11: While reset is high, `irr_o` is 0 and `bus_req_o` and `msg_valid_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_pin_i | input | 24 | Raw interrupt pins, polarity by index |
| gpio_mode_i | input | 4 | Per shared pin: 1 = GPIO mode, hides line 20+k |
| trig_level_i | input | 24 | Per line: 1 = level mode, 0 = edge mode |
| mask_i | input | 24 | Per line: 1 = suppress messages |
| vec_base_i | input | 8 | Vector base added to the line index |
| dest_i | input | 8 | Destination field placed in the address |
| irr_o | output | 24 | Interrupt request register |
| bus_req_o | output | 1 | Upstream bus request |
| bus_gnt_i | input | 1 | Upstream grant (buffers flushed) |
| msg_valid_o | output | 1 | Message write valid |
| msg_ready_i | input | 1 | Message write accepted |
| msg_addr_o | output | 32 | Message address |
| msg_data_o | output | 32 | Message data |

## Verification
The bench builds the block with its default parameters: 24 lines, active-low from index 16, and four shared lines from index 20. With these values every polarity class, the GPIO gating, and the wrap of the 8-bit vector sum near a base of 0xF0 can be reached. Holding the grant low makes events pile up, which exposes the arbiter order and the merging of level changes. Holding ready low keeps a write in flight while new edges arrive. A random phase with per-line modes, random masks and a random ready pattern covers all 24 indices against a bench model of the expected message.

// File: rtl/irqmsg_pkg.sv
package irqmsg_pkg;

    localparam int IRQ_N      = 24;
    localparam int IDX_W      = $clog2(IRQ_N);
    localparam int VEC_W      = 8;
    localparam int DEST_W     = 8;
    localparam int ADDR_W     = 32;
    localparam int DATA_W     = 32;
    localparam int ASSERT_BIT = 14;
    localparam int TRIG_BIT   = 15;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_REQ,
        ST_SEND
    } xmit_state_e;

    typedef struct packed {
        logic [IDX_W-1:0]  idx;
        logic              asserted;
        logic              level;
        logic [VEC_W-1:0]  vec;
        logic [DEST_W-1:0] dest;
    } evt_t;

    function automatic logic [ADDR_W-1:0] build_addr(
        input logic [ADDR_W-1:0] base,
        input int unsigned       dest_lsb,
        input logic [DEST_W-1:0] dest
    );
        return base | (ADDR_W'(dest) << dest_lsb);
    endfunction

    function automatic logic [DATA_W-1:0] build_data(input evt_t e);
        logic [DATA_W-1:0] w;
        w = '0;
        w[VEC_W-1:0]  = e.vec;
        w[ASSERT_BIT] = e.asserted;
        w[TRIG_BIT]   = e.level;
        return w;
    endfunction

    function automatic logic [IDX_W-1:0] lowest_set(input logic [IRQ_N-1:0] v);
        logic [IDX_W-1:0] r;
        r = '0;
        for (int i = IRQ_N - 1; i >= 0; i--) begin
            if (v[i]) r = IDX_W'(i);
        end
        return r;
    endfunction

endpackage

// File: rtl/irqmsg_line_cond.sv
module irqmsg_line_cond
    import irqmsg_pkg::*;
#(
    parameter int ACTLOW_FIRST = 16,
    parameter int SHARE_FIRST  = 20,
    parameter int SHARE_N      = 4
) (
    input  logic [IRQ_N-1:0]   pin_i,
    input  logic [SHARE_N-1:0] gpio_mode_i,
    output logic [IRQ_N-1:0]   norm_o
);

    for (genvar i = 0; i < IRQ_N; i++) begin : g_line
        logic act;
        if (i >= ACTLOW_FIRST) begin : g_low
            assign act = ~pin_i[i];
        end else begin : g_high
            assign act = pin_i[i];
        end
        if (i >= SHARE_FIRST && i < SHARE_FIRST + SHARE_N) begin : g_shared
            assign norm_o[i] = act & ~gpio_mode_i[i - SHARE_FIRST];
        end else begin : g_plain
            assign norm_o[i] = act;
        end
    end

endmodule

// File: rtl/irqmsg_detect.sv
module irqmsg_detect
    import irqmsg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [IRQ_N-1:0] norm_i,
    input  logic [IRQ_N-1:0] level_i,
    input  logic [IRQ_N-1:0] mask_i,
    input  logic             take_vld_i,
    input  logic [IDX_W-1:0] take_idx_i,
    input  logic             done_vld_i,
    input  logic [IDX_W-1:0] done_idx_i,
    output logic [IRQ_N-1:0] irr_o,
    output logic [IRQ_N-1:0] pend_o,
    output logic [IRQ_N-1:0] pol_o
);

    logic [IRQ_N-1:0] prev_q;
    logic [IRQ_N-1:0] rise, chg, ev, ev_msg;
    logic [IRQ_N-1:0] take_oh, done_oh;

    always_comb begin
        rise    = norm_i & ~prev_q;
        chg     = norm_i ^ prev_q;
        ev      = (level_i & chg) | (~level_i & rise);
        ev_msg  = ev & ~mask_i;
        take_oh = take_vld_i ? (IRQ_N'(1) << take_idx_i) : '0;
        done_oh = done_vld_i ? (IRQ_N'(1) << done_idx_i) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            irr_o  <= '0;
            pend_o <= '0;
            pol_o  <= '0;
        end else begin
            prev_q <= norm_i;
            pend_o <= ev_msg | (pend_o & ~take_oh);
            pol_o  <= (ev_msg & (norm_i | ~level_i)) | (~ev_msg & pol_o);
            irr_o  <= (level_i & norm_i)
                    | (~level_i & ((rise & ~mask_i) | (irr_o & ~done_oh)));
        end
    end

endmodule

// File: rtl/irqmsg_arb.sv
module irqmsg_arb
    import irqmsg_pkg::*;
(
    input  logic [IRQ_N-1:0] pend_i,
    output logic             any_o,
    output logic [IDX_W-1:0] win_o
);

    assign any_o = |pend_i;
    assign win_o = lowest_set(pend_i);

endmodule

// File: rtl/irqmsg_xmit.sv
module irqmsg_xmit
    import irqmsg_pkg::*;
#(
    parameter logic [ADDR_W-1:0] ADDR_BASE = 32'hFEE0_0000,
    parameter int unsigned       DEST_LSB  = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              any_i,
    input  logic [IDX_W-1:0]  win_i,
    input  logic [IRQ_N-1:0]  pol_i,
    input  logic [IRQ_N-1:0]  level_i,
    input  logic [VEC_W-1:0]  vec_base_i,
    input  logic [DEST_W-1:0] dest_i,
    input  logic              gnt_i,
    input  logic              ready_i,
    output logic              take_vld_o,
    output logic [IDX_W-1:0]  take_idx_o,
    output logic              done_vld_o,
    output logic [IDX_W-1:0]  done_idx_o,
    output logic              bus_req_o,
    output logic              valid_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] data_o
);

    xmit_state_e state_q;
    evt_t        cur_q;

    assign take_vld_o = (state_q == ST_IDLE) && any_i;
    assign take_idx_o = win_i;
    assign done_vld_o = (state_q == ST_SEND) && ready_i;
    assign done_idx_o = cur_q.idx;
    assign bus_req_o  = (state_q == ST_REQ);
    assign valid_o    = (state_q == ST_SEND);
    assign addr_o     = build_addr(ADDR_BASE, DEST_LSB, cur_q.dest);
    assign data_o     = build_data(cur_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cur_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (any_i) begin
                        cur_q.idx      <= win_i;
                        cur_q.asserted <= pol_i[win_i];
                        cur_q.level    <= level_i[win_i];
                        cur_q.vec      <= vec_base_i + VEC_W'(win_i);
                        cur_q.dest     <= dest_i;
                        state_q        <= ST_REQ;
                    end
                end
                ST_REQ:  if (gnt_i)   state_q <= ST_SEND;
                ST_SEND: if (ready_i) state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/irqmsg_gen.sv
module irqmsg_gen
    import irqmsg_pkg::*;
#(
    parameter int                ACTLOW_FIRST = 16,
    parameter int                SHARE_FIRST  = 20,
    parameter int                SHARE_N      = 4,
    parameter logic [ADDR_W-1:0] ADDR_BASE    = 32'hFEE0_0000,
    parameter int unsigned       DEST_LSB     = 12
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [IRQ_N-1:0]   irq_pin_i,
    input  logic [SHARE_N-1:0] gpio_mode_i,
    input  logic [IRQ_N-1:0]   trig_level_i,
    input  logic [IRQ_N-1:0]   mask_i,
    input  logic [VEC_W-1:0]   vec_base_i,
    input  logic [DEST_W-1:0]  dest_i,
    output logic [IRQ_N-1:0]   irr_o,
    output logic               bus_req_o,
    input  logic               bus_gnt_i,
    output logic               msg_valid_o,
    input  logic               msg_ready_i,
    output logic [ADDR_W-1:0]  msg_addr_o,
    output logic [DATA_W-1:0]  msg_data_o
);

    logic [IRQ_N-1:0] norm, pend, pol;
    logic             any, take_vld, done_vld;
    logic [IDX_W-1:0] win, take_idx, done_idx;

    irqmsg_line_cond #(
        .ACTLOW_FIRST (ACTLOW_FIRST),
        .SHARE_FIRST  (SHARE_FIRST),
        .SHARE_N      (SHARE_N)
    ) u_cond (
        .pin_i       (irq_pin_i),
        .gpio_mode_i (gpio_mode_i),
        .norm_o      (norm)
    );

    irqmsg_detect u_det (
        .clk        (clk),
        .rst        (rst),
        .norm_i     (norm),
        .level_i    (trig_level_i),
        .mask_i     (mask_i),
        .take_vld_i (take_vld),
        .take_idx_i (take_idx),
        .done_vld_i (done_vld),
        .done_idx_i (done_idx),
        .irr_o      (irr_o),
        .pend_o     (pend),
        .pol_o      (pol)
    );

    irqmsg_arb u_arb (
        .pend_i (pend),
        .any_o  (any),
        .win_o  (win)
    );

    irqmsg_xmit #(
        .ADDR_BASE (ADDR_BASE),
        .DEST_LSB  (DEST_LSB)
    ) u_xmit (
        .clk        (clk),
        .rst        (rst),
        .any_i      (any),
        .win_i      (win),
        .pol_i      (pol),
        .level_i    (trig_level_i),
        .vec_base_i (vec_base_i),
        .dest_i     (dest_i),
        .gnt_i      (bus_gnt_i),
        .ready_i    (msg_ready_i),
        .take_vld_o (take_vld),
        .take_idx_o (take_idx),
        .done_vld_o (done_vld),
        .done_idx_o (done_idx),
        .bus_req_o  (bus_req_o),
        .valid_o    (msg_valid_o),
        .addr_o     (msg_addr_o),
        .data_o     (msg_data_o)
    );

endmodule

// File: rtl/irqmsg_gen_chk.sv
module irqmsg_gen_chk
    import irqmsg_pkg::*;
#(
    parameter int ACTLOW_FIRST = 16,
    parameter int SHARE_FIRST  = 20,
    parameter int SHARE_N      = 4
) (
    input logic               clk,
    input logic               rst,
    input logic [IRQ_N-1:0]   irq_pin_i,
    input logic [SHARE_N-1:0] gpio_mode_i,
    input logic [IRQ_N-1:0]   trig_level_i,
    input logic [IRQ_N-1:0]   irr_o,
    input logic               bus_req_o,
    input logic               bus_gnt_i,
    input logic               msg_valid_o,
    input logic               msg_ready_i,
    input logic [ADDR_W-1:0]  msg_addr_o,
    input logic [DATA_W-1:0]  msg_data_o
);

    logic past_ok;
    always_ff @(posedge clk) begin
        if (rst) past_ok <= 1'b0;
        else     past_ok <= 1'b1;
    end

    a_r11_reset_quiet: assert property (@(posedge clk)
        rst |=> (irr_o == '0 && !bus_req_o && !msg_valid_o));

    a_r6_req_held: assert property (@(posedge clk) disable iff (rst)
        (bus_req_o && !bus_gnt_i) |=> bus_req_o);

    a_r6_valid_after_grant: assert property (@(posedge clk) disable iff (rst)
        $rose(msg_valid_o) |-> $past(bus_req_o && bus_gnt_i));

    a_r6_req_valid_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(bus_req_o && msg_valid_o));

    a_r7_msg_stable: assert property (@(posedge clk) disable iff (rst)
        (msg_valid_o && !msg_ready_i) |=>
            (msg_valid_o && $stable(msg_addr_o) && $stable(msg_data_o)));

    for (genvar i = 0; i < ACTLOW_FIRST; i++) begin : g_lvl
        a_r4_level_follow: assert property (@(posedge clk) disable iff (rst)
            (past_ok && $past(trig_level_i[i])) |-> (irr_o[i] == $past(irq_pin_i[i])));
    end

    for (genvar k = 0; k < SHARE_N; k++) begin : g_gpio
        a_r2_gpio_hidden: assert property (@(posedge clk) disable iff (rst)
            (past_ok && $past(gpio_mode_i[k]) && $past(trig_level_i[SHARE_FIRST + k]))
                |-> !irr_o[SHARE_FIRST + k]);
    end

endmodule

bind irqmsg_gen irqmsg_gen_chk #(
    .ACTLOW_FIRST (ACTLOW_FIRST),
    .SHARE_FIRST  (SHARE_FIRST),
    .SHARE_N      (SHARE_N)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .irq_pin_i    (irq_pin_i),
    .gpio_mode_i  (gpio_mode_i),
    .trig_level_i (trig_level_i),
    .irr_o        (irr_o),
    .bus_req_o    (bus_req_o),
    .bus_gnt_i    (bus_gnt_i),
    .msg_valid_o  (msg_valid_o),
    .msg_ready_i  (msg_ready_i),
    .msg_addr_o   (msg_addr_o),
    .msg_data_o   (msg_data_o)
);

// File: tb/tb_irqmsg_gen.sv
module tb_irqmsg_gen;

    logic        clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst;
    logic [23:0] pins, act, lvl_mode, mask;
    logic [3:0]  gpio;
    logic [7:0]  vec_base, dest;
    logic        gnt, rdy_man, rdy_rnd, rnd_on;
    wire         msg_ready = rnd_on ? rdy_rnd : rdy_man;

    logic [23:0] irr;
    logic        bus_req, msg_valid;
    logic [31:0] msg_addr, msg_data;

    irqmsg_gen dut (
        .clk          (clk),
        .rst          (rst),
        .irq_pin_i    (pins),
        .gpio_mode_i  (gpio),
        .trig_level_i (lvl_mode),
        .mask_i       (mask),
        .vec_base_i   (vec_base),
        .dest_i       (dest),
        .irr_o        (irr),
        .bus_req_o    (bus_req),
        .bus_gnt_i    (gnt),
        .msg_valid_o  (msg_valid),
        .msg_ready_i  (msg_ready),
        .msg_addr_o   (msg_addr),
        .msg_data_o   (msg_data)
    );

    int          checks = 0;
    int          errors = 0;
    logic [63:0] mq[$];
    logic        granted = 1'b0;

    function automatic logic [31:0] exp_addr(input logic [7:0] d);
        return 32'hFEE0_0000 | ({24'h0, d} << 12);
    endfunction

    function automatic logic [31:0] exp_data(input int idx, input bit a, input bit l);
        logic [7:0] v;
        v = vec_base + 8'(idx);
        return {16'h0, l, a, 6'h0, v};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic set_line(input int i, input bit a);
        @(posedge clk); #2;
        act[i]  = a;
        pins[i] = (i >= 16) ? ~a : a;
    endtask

    task automatic expect_msg(input int idx, input bit a, input bit l, input string req);
        logic [63:0] exp, got;
        int n;
        exp = {exp_addr(dest), exp_data(idx, a, l)};
        n = 0;
        while (mq.size() == 0 && n < 60) begin
            @(negedge clk);
            n++;
        end
        if (mq.size() == 0) begin
            check(1'b0, req, $sformatf("missing message for line %0d", idx), 64'h0, exp);
        end else begin
            got = mq.pop_front();
            check(got == exp, req, $sformatf("message for line %0d", idx), got, exp);
        end
    endtask

    task automatic expect_none(input int cyc, input string req);
        repeat (cyc) @(negedge clk);
        check(mq.size() == 0, req, "unexpected message",
              (mq.size() == 0) ? 64'h0 : mq[0], 64'h0);
        mq.delete();
    endtask

    task automatic chk_irr(input int i, input bit e, input string req);
        check(irr[i] == e, req, $sformatf("irr bit %0d", i), 64'(irr[i]), 64'(e));
    endtask

    always @(negedge clk) begin
        if (rst) begin
            granted = 1'b0;
        end else begin
            if (bus_req && gnt) granted = 1'b1;
            if (bus_req && msg_valid)
                check(1'b0, "R6", "request and valid together", 64'h1, 64'h0);
            if (msg_valid && msg_ready) begin
                check(granted, "R6", "grant before write", 64'(granted), 64'h1);
                granted = 1'b0;
                mq.push_back({msg_addr, msg_data});
            end
        end
    end

    always @(posedge clk) begin
        #2;
        if (rnd_on) rdy_rnd = 1'($urandom_range(0, 1));
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual hung expected finished run");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [63:0] cap;
        int          n;
        void'($urandom(32'd4711));
        rst = 1'b1;
        act = '0;
        pins = 24'hFF0000;
        gpio = '0; lvl_mode = '0; mask = '0;
        vec_base = 8'h20; dest = 8'h03;
        gnt = 1'b1; rdy_man = 1'b1; rdy_rnd = 1'b1; rnd_on = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(irr == '0 && !bus_req && !msg_valid, "R11", "reset state",
              {38'h0, irr, bus_req, msg_valid}, 64'h0);
        @(posedge clk); #2; rst = 1'b0;

        // R3 / R9 / R10: edge on line 5
        set_line(5, 1'b1);
        expect_msg(5, 1'b1, 1'b0, "R3");
        repeat (2) @(negedge clk);
        chk_irr(5, 1'b0, "R10");
        set_line(5, 1'b0);
        expect_none(10, "R3");

        // R1: active-low line 17 (PCI wire B)
        set_line(17, 1'b1);
        @(negedge clk); @(negedge clk);
        chk_irr(17, 1'b1, "R1");
        expect_msg(17, 1'b1, 1'b0, "R1");
        set_line(17, 1'b0);
        expect_none(8, "R1");

        // R4: level mode on line 7
        @(posedge clk); #2; lvl_mode[7] = 1'b1;
        set_line(7, 1'b1);
        @(negedge clk);
        chk_irr(7, 1'b0, "R4");
        @(negedge clk);
        chk_irr(7, 1'b1, "R4");
        expect_msg(7, 1'b1, 1'b1, "R4");
        set_line(7, 1'b0);
        expect_msg(7, 1'b0, 1'b1, "R4");
        chk_irr(7, 1'b0, "R4");

        // R5: masking in both modes
        @(posedge clk); #2; mask[9] = 1'b1; mask[11] = 1'b1; lvl_mode[11] = 1'b1;
        set_line(9, 1'b1);
        expect_none(10, "R5");
        chk_irr(9, 1'b0, "R5");
        set_line(9, 1'b0);
        set_line(11, 1'b1);
        expect_none(10, "R5");
        chk_irr(11, 1'b1, "R5");
        set_line(11, 1'b0);
        expect_none(6, "R5");

        // R2: GPIO gating on line 21, vector wrap (R9), wire A on line 16
        @(posedge clk); #2; gpio = 4'b0010; vec_base = 8'hF0;
        set_line(21, 1'b1);
        expect_none(10, "R2");
        chk_irr(21, 1'b0, "R2");
        @(posedge clk); #2; gpio = 4'b0000;
        expect_msg(21, 1'b1, 1'b0, "R9");
        set_line(21, 1'b0);
        set_line(16, 1'b1);
        expect_msg(16, 1'b1, 1'b0, "R2");
        set_line(16, 1'b0);
        expect_none(6, "R2");
        @(posedge clk); #2; vec_base = 8'h20;

        // R8 / R6: priority while grant withheld
        @(posedge clk); #2; gnt = 1'b0;
        @(posedge clk); #2;
        act[12] = 1'b1; act[4] = 1'b1; act[8] = 1'b1;
        pins[12] = 1'b1; pins[4] = 1'b1; pins[8] = 1'b1;
        repeat (4) @(negedge clk);
        check(bus_req && !msg_valid, "R6", "request waits for grant",
              {62'h0, bus_req, msg_valid}, 64'h2);
        @(posedge clk); #2; gnt = 1'b1;
        expect_msg(4, 1'b1, 1'b0, "R8");
        expect_msg(8, 1'b1, 1'b0, "R8");
        expect_msg(12, 1'b1, 1'b0, "R8");
        set_line(4, 1'b0); set_line(8, 1'b0); set_line(12, 1'b0);
        expect_none(6, "R8");

        // R7 / R10: write held by ready, edge arrives meanwhile
        @(posedge clk); #2; rdy_man = 1'b0;
        set_line(6, 1'b1);
        n = 0;
        while (!msg_valid && n < 20) begin
            @(negedge clk);
            n++;
        end
        cap = {msg_addr, msg_data};
        set_line(2, 1'b1);
        repeat (4) @(negedge clk);
        check(msg_valid && {msg_addr, msg_data} == cap, "R7", "held write",
              {msg_addr, msg_data}, cap);
        chk_irr(2, 1'b1, "R10");
        @(posedge clk); #2; rdy_man = 1'b1;
        expect_msg(6, 1'b1, 1'b0, "R7");
        expect_msg(2, 1'b1, 1'b0, "R10");
        set_line(6, 1'b0); set_line(2, 1'b0);
        expect_none(6, "R10");

        // R4 merge: two level changes while busy
        @(posedge clk); #2; gnt = 1'b0; lvl_mode[10] = 1'b1;
        set_line(0, 1'b1);
        repeat (3) @(negedge clk);
        set_line(10, 1'b1);
        repeat (2) @(negedge clk);
        set_line(10, 1'b0);
        repeat (2) @(negedge clk);
        @(posedge clk); #2; gnt = 1'b1;
        expect_msg(0, 1'b1, 1'b0, "R8");
        expect_msg(10, 1'b0, 1'b1, "R4");
        expect_none(10, "R4");
        set_line(0, 1'b0);
        expect_none(4, "R3");

        // Random phase
        @(posedge clk); #2;
        rst = 1'b1; act = '0; pins = 24'hFF0000; mask = '0; gpio = '0;
        repeat (3) @(posedge clk);
        #2; rst = 1'b0;
        lvl_mode = 24'($urandom);
        mq.delete();
        rnd_on = 1'b1;
        for (int it = 0; it < 150; it++) begin
            int idx;
            bit m, nv, lv;
            idx = $urandom_range(0, 23);
            m   = ($urandom_range(0, 3) == 0);
            @(posedge clk); #2;
            mask[idx] = m;
            vec_base  = 8'($urandom);
            dest      = 8'($urandom);
            nv = ~act[idx];
            lv = lvl_mode[idx];
            set_line(idx, nv);
            if (!m && (lv || nv)) begin
                expect_msg(idx, nv, lv, lv ? "R4" : "R3");
            end else begin
                expect_none(8, m ? "R5" : "R3");
            end
            repeat (2) @(negedge clk);
            chk_irr(idx, lv ? nv : 1'b0, lv ? "R4" : "R10");
        end
        rnd_on = 1'b0;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule